// File: doc/BRIEF.md
# Injected Conversion Trigger Sequencer

This block decides when a filter channel group starts a conversion and which channel each conversion uses. Eight external trigger lines pass through a two-flop synchronizer. One line is selected, and its rising edges, falling edges or both raise start requests. Start requests can also come from a software start bit in the control word, or from a start pulse issued by a master instance that the block follows in lock-step.

Each accepted request drives a one-cycle `startReq` pulse together with a channel index taken from a sparse channel mask. In single-step mode the block converts one channel per request and moves a pointer round the selected channels. In scan mode one request walks every selected channel in ascending order, and each conversion-done handshake moves the walk to the next channel. The configuration fields are locked while the global enable is high.

Top module: `inj_trigger_seq`

## Requirements
- R1: The control word bits [1:0] set the edge mode: 0 disables trigger detection, 1 means rising edges, 2 means falling edges, 3 means both edges. Each qualifying edge of the selected synchronized trigger raises exactly one start request. The `startReq` pulse appears three rising clock edges after the trigger input changes.
- R2: Control word bits [4:2] select which of the eight trigger inputs is watched, by its index 0 to 7. Edges on the other seven inputs raise no request.
- R3: Control word bit 5 is the scan mode, bit 6 is the DMA enable and bit 7 is the sync mode. These fields and the edge and select fields take a write to address 0 only while `globalEn` is 0. Writes made while enabled leave them unchanged, and the unchanged values read back at address 0.
- R4: With scan mode 0, each request converts one selected channel. The pointer then advances to the next selected channel above it, and after the highest selected channel it wraps to the lowest.
- R5: With scan mode 1, each request converts all selected channels in ascending order, starting from the lowest. The next channel's `startReq` is issued in the cycle after `convDone` is sampled.
- R6: With scan mode 0, a write of the channel mask (address 1, bits [7:0]) makes the next single-step request use the lowest selected channel.
- R7: With sync mode 1 and the block enabled, a high `syncStartIn` at a clock edge launches a conversion at that same edge. `startReq` is high in the following cycle.
- R8: Control word bit 8 is the software start. It always reads back as 0. Writing 1 launches a conversion when the block is enabled, idle and not in sync mode. The write is ignored when a conversion is in progress or when sync mode is 1.
- R9: Requests of any source that arrive while `busy` is 1 are dropped. `busy` falls at the clock edge that samples `convDone` for the last channel of the request.
- R10: With an all-zero channel mask, every request is ignored: no `startReq` is issued and `busy` stays 0.
- R11: After reset, `startReq` and `busy` are 0 and both register addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigIn | input | 8 | Asynchronous trigger lines |
| syncStartIn | input | 1 | Software launch pulse from the master instance |
| globalEn | input | 1 | Block enable; locks configuration when high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write address: 0 control word, 1 channel mask |
| wrData | input | 16 | Write data |
| rdAddr | input | 1 | Read address |
| rdData | output | 16 | Read data for rdAddr |
| convDone | input | 1 | Conversion of the current channel finished |
| startReq | output | 1 | One-cycle conversion start pulse |
| startChan | output | 3 | Channel index for startReq |
| busy | output | 1 | Conversion or scan in progress |

## Verification
The bench sweeps every edge mode against every trigger select, and drives edges on both the selected line and a neighbouring line. A wrong edge decode, or a mux off by one, shows up as a wrong request count. A sparse mask of channels 2, 5 and 7 checks that the single-step pointer wraps and restarts after a mask write, and that scan mode restarts at the lowest channel. A design that skipped empty bit positions wrongly, or kept the pointer after a mask write, would issue the wrong channel. Requests are also fired while busy, with the mask empty, and with a software start in sync mode. A design that queued these requests, or let them through, would produce extra pulses or leave `busy` set.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edgeMode_e;

  // Strobes from control to the channel datapath
  typedef struct packed {
    logic launch;    // accepted start request
    logic ptrReset;  // restart single-step walk at lowest channel
  } seqStrobe_t;

endpackage

// File: rtl/inj_seq_ctrl.sv
module inj_seq_ctrl
  import inj_seq_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int NUM_CHAN = 8,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic                syncStartIn,
  input  logic                globalEn,
  input  logic                wrEn,
  input  logic                wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic                busyIn,
  output logic                scanMode,
  output logic [NUM_CHAN-1:0] chanMask,
  output seqStrobe_t          strobe
);

  localparam int SEL_W    = $clog2(NUM_TRIG);
  localparam int SEL_LSB  = 2;
  localparam int SCAN_BIT = SEL_LSB + SEL_W;
  localparam int DMA_BIT  = SCAN_BIT + 1;
  localparam int SYNC_BIT = SCAN_BIT + 2;
  localparam int SW_BIT   = SCAN_BIT + 3;

  edgeMode_e          edgeMode;
  logic [SEL_W-1:0]   trigSel;
  logic               dmaEn;
  logic               syncMode;
  logic [NUM_TRIG-1:0] trigMeta, trigSync;
  logic               selNow, selPrev;
  logic               ctrlWr, maskWr;
  logic               trigHit, swHit, syncHit;

  assign ctrlWr = wrEn && (wrAddr == 1'b0);
  assign maskWr = wrEn && (wrAddr == 1'b1);
  assign selNow = trigSync[trigSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeMode <= EDGE_OFF;
      trigSel  <= '0;
      scanMode <= 1'b0;
      dmaEn    <= 1'b0;
      syncMode <= 1'b0;
      chanMask <= '0;
      trigMeta <= '0;
      trigSync <= '0;
      selPrev  <= 1'b0;
    end else begin
      if (ctrlWr && !globalEn) begin
        edgeMode <= edgeMode_e'(wrData[1:0]);
        trigSel  <= wrData[SEL_LSB +: SEL_W];
        scanMode <= wrData[SCAN_BIT];
        dmaEn    <= wrData[DMA_BIT];
        syncMode <= wrData[SYNC_BIT];
      end
      if (maskWr) chanMask <= wrData[NUM_CHAN-1:0];
      trigMeta <= trigIn;
      trigSync <= trigMeta;
      selPrev  <= selNow;
    end
  end

  always_comb begin
    unique case (edgeMode)
      EDGE_RISE: trigHit = selNow && !selPrev;
      EDGE_FALL: trigHit = !selNow && selPrev;
      EDGE_BOTH: trigHit = selNow ^ selPrev;
      default:   trigHit = 1'b0;
    endcase
  end

  assign swHit   = ctrlWr && wrData[SW_BIT] && !syncMode;
  assign syncHit = syncMode && syncStartIn;

  assign strobe.launch   = globalEn && (|chanMask) && !busyIn &&
                           (trigHit || swHit || syncHit);
  assign strobe.ptrReset = maskWr && !scanMode;

  always_comb begin
    rdData = '0;
    if (rdAddr == 1'b0) begin
      rdData[1:0]               = edgeMode;
      rdData[SEL_LSB +: SEL_W]  = trigSel;
      rdData[SCAN_BIT]          = scanMode;
      rdData[DMA_BIT]           = dmaEn;
      rdData[SYNC_BIT]          = syncMode;
    end else begin
      rdData[NUM_CHAN-1:0]      = chanMask;
    end
  end

  // Configuration may not move across an edge at which the block was enabled
  assert_cfg_lock_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(globalEn) |-> ($stable(edgeMode) && $stable(trigSel) &&
                         $stable(scanMode) && $stable(dmaEn) && $stable(syncMode)));

endmodule

// File: rtl/inj_seq_path.sv
module inj_seq_path
  import inj_seq_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                scanMode,
  input  logic [NUM_CHAN-1:0] chanMask,
  input  logic                convDone,
  output logic                startReq,
  output logic [$clog2(NUM_CHAN)-1:0] startChan,
  output logic                busy
);

  localparam int CHAN_W = $clog2(NUM_CHAN);

  logic [CHAN_W-1:0] ptr, curChan, nextIdx, lowIdx, aboveIdx, firstChan;
  logic              aboveFound, scanRun;

  // Lowest selected channel, first selected at/after ptr, first above curChan
  always_comb begin
    lowIdx     = '0;
    aboveIdx   = '0;
    aboveFound = 1'b0;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (chanMask[i]) lowIdx = CHAN_W'(i);
      if (chanMask[i] && (i > int'(curChan))) begin
        aboveIdx   = CHAN_W'(i);
        aboveFound = 1'b1;
      end
    end
    nextIdx = lowIdx;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (chanMask[(int'(ptr) + i) % NUM_CHAN])
        nextIdx = CHAN_W'((int'(ptr) + i) % NUM_CHAN);
    end
  end

  assign firstChan = scanMode ? lowIdx : nextIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      startReq  <= 1'b0;
      startChan <= '0;
      curChan   <= '0;
      ptr       <= '0;
      scanRun   <= 1'b0;
    end else begin
      startReq <= 1'b0;
      if (strobe.launch) begin
        busy      <= 1'b1;
        scanRun   <= scanMode;
        curChan   <= firstChan;
        startChan <= firstChan;
        startReq  <= 1'b1;
      end else if (busy && convDone) begin
        if (scanRun && aboveFound) begin
          curChan   <= aboveIdx;
          startChan <= aboveIdx;
          startReq  <= 1'b1;
        end else begin
          busy <= 1'b0;
          if (!scanRun)
            ptr <= (int'(curChan) == NUM_CHAN - 1) ? '0 : curChan + 1'b1;
        end
      end
      if (strobe.ptrReset) ptr <= '0;
    end
  end

  assert_launch_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |-> !busy);

  assert_launch_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |=> (startReq && busy));

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> busy);

  assert_busy_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(convDone));

  assert_empty_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |-> (chanMask != '0));

endmodule

// File: rtl/inj_trigger_seq.sv
module inj_trigger_seq
  import inj_seq_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int NUM_CHAN = 8,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic                syncStartIn,
  input  logic                globalEn,
  input  logic                wrEn,
  input  logic                wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic                convDone,
  output logic                startReq,
  output logic [$clog2(NUM_CHAN)-1:0] startChan,
  output logic                busy
);

  seqStrobe_t          strobe;
  logic                scanMode;
  logic [NUM_CHAN-1:0] chanMask;

  inj_seq_ctrl #(.NUM_TRIG(NUM_TRIG), .NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .syncStartIn(syncStartIn),
    .globalEn(globalEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busyIn(busy), .scanMode(scanMode),
    .chanMask(chanMask), .strobe(strobe)
  );

  inj_seq_path #(.NUM_CHAN(NUM_CHAN)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanMode(scanMode),
    .chanMask(chanMask), .convDone(convDone), .startReq(startReq),
    .startChan(startChan), .busy(busy)
  );

endmodule

// File: tb/sim_inj_trigger_seq.sv
module sim_inj_trigger_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  trigIn = '0;
  logic        syncStartIn = 1'b0;
  logic        globalEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdAddr = 1'b0;
  logic [15:0] rdData;
  logic        convDone;
  logic        startReq;
  logic [2:0]  startChan;
  logic        busy;
  logic        autoDone = 1'b1;
  logic        manualDone = 1'b0;

  always #4 clk = ~clk;

  assign convDone = (autoDone & startReq) | manualDone;

  inj_trigger_seq u0 (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .syncStartIn(syncStartIn),
    .globalEn(globalEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .convDone(convDone),
    .startReq(startReq), .startChan(startChan), .busy(busy)
  );

  int         logCnt = 0;
  logic [2:0] logChan [0:63];
  int         nChecks = 0;
  int         nFail = 0;
  logic [7:0] ctrlWord = '0;
  bit         done = 0;

  always @(negedge clk) begin
    if (rstN && startReq) begin
      if (logCnt < 64) logChan[logCnt] = startChan;
      logCnt++;
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(bit addr, logic [15:0] d);
    wrEn = 1'b1; wrAddr = addr; wrData = d;
    tick(1);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic setCtrl(int edgeM, int sel, bit scan, bit dma, bit sync);
    ctrlWord = {sync, dma, scan, 3'(sel), 2'(edgeM)};
    wrReg(1'b0, {8'h00, ctrlWord});
  endtask

  task automatic swStart();
    wrReg(1'b0, {7'h00, 1'b1, ctrlWord});
  endtask

  task automatic readReg(bit addr, output logic [15:0] v);
    rdAddr = addr;
    #1 v = rdData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog R9: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    int base, expN;
    tick(3);
    // R11 reset state
    #1;
    check("R11 startReq", int'(startReq), 0);
    check("R11 busy", int'(busy), 0);
    readReg(1'b0, v); check("R11 ctrl readback", int'(v), 0);
    readReg(1'b1, v); check("R11 mask readback", int'(v), 0);
    tick(1);
    rstN = 1'b1;
    tick(2);

    // R1 latency: rising on input 3
    wrReg(1'b1, 16'h0001);
    setCtrl(1, 3, 0, 0, 0);
    globalEn = 1'b1;
    tick(2);
    trigIn[3] = 1'b1;
    tick(2); #1;
    check("R1 no pulse before third edge", int'(startReq), 0);
    tick(1); #1;
    check("R1 pulse at third edge", int'(startReq), 1);
    tick(4);
    trigIn[3] = 1'b0;
    tick(6);

    // R1/R2 sweep: every mode against every select
    for (int sel = 0; sel < 8; sel++) begin
      for (int m = 0; m < 4; m++) begin
        globalEn = 1'b0;
        setCtrl(m, sel, 0, 0, 0);
        globalEn = 1'b1;
        tick(3);
        base = logCnt;
        trigIn[sel] = 1'b1; tick(6);
        trigIn[sel] = 1'b0; tick(6);
        trigIn[(sel + 1) % 8] = 1'b1; tick(6);
        trigIn[(sel + 1) % 8] = 1'b0; tick(6);
        expN = (m & 1) + (m >> 1);
        check($sformatf("R1 R2 mode %0d sel %0d requests", m, sel), logCnt - base, expN);
      end
    end

    // R3 lock while enabled, unlock while disabled
    globalEn = 1'b0;
    setCtrl(1, 2, 0, 0, 0);
    globalEn = 1'b1;
    wrReg(1'b0, 16'h00FF);
    readReg(1'b0, v); check("R3 locked fields unchanged", int'(v), 16'h0009);
    globalEn = 1'b0;
    setCtrl(1, 2, 0, 1, 0);
    readReg(1'b0, v); check("R3 DMA bit accepted when disabled", int'(v), 16'h0049);
    // R8 software start bit reads 0
    swStart();
    readReg(1'b0, v); check("R8 software start reads 0", int'(v[8]), 0);
    check("R8 no launch while disabled", int'(busy), 0);

    // R4 single-step over sparse mask {2,5,7} with wrap
    setCtrl(1, 2, 0, 0, 0);
    wrReg(1'b1, 16'h00A4);
    globalEn = 1'b1;
    base = logCnt;
    for (int k = 0; k < 5; k++) begin swStart(); tick(2); end
    check("R4 step count", logCnt - base, 5);
    check("R4 step 1", int'(logChan[base]), 2);
    check("R4 step 2", int'(logChan[base + 1]), 5);
    check("R4 step 3", int'(logChan[base + 2]), 7);
    check("R4 wrap to lowest", int'(logChan[base + 3]), 2);
    check("R4 step 5", int'(logChan[base + 4]), 5);
    // R6 mask write restarts walk
    wrReg(1'b1, 16'h00A4);
    base = logCnt;
    swStart(); tick(2);
    check("R6 restart at lowest", int'(logChan[base]), 2);

    // R5 scan mode
    globalEn = 1'b0;
    setCtrl(1, 0, 1, 0, 0);
    globalEn = 1'b1;
    base = logCnt;
    swStart(); tick(5);
    swStart(); tick(5);
    check("R5 scan count", logCnt - base, 6);
    for (int k = 0; k < 6; k++)
      check($sformatf("R5 scan order %0d", k), int'(logChan[base + k]),
            (k % 3 == 0) ? 2 : ((k % 3 == 1) ? 5 : 7));

    // R9 drops while busy, busy falls on last done
    autoDone = 1'b0;
    base = logCnt;
    swStart(); #1;
    check("R9 first channel issued", int'(startChan), 2);
    tick(2);
    swStart();
    trigIn[0] = 1'b1; tick(5);
    trigIn[0] = 1'b0; tick(5); #1;
    check("R9 requests dropped while busy", logCnt - base, 1);
    check("R9 busy held", int'(busy), 1);
    manualDone = 1'b1; tick(1); manualDone = 1'b0; #1;
    check("R9 R5 second channel", int'(startChan), 5);
    tick(2);
    manualDone = 1'b1; tick(1); manualDone = 1'b0; #1;
    check("R9 R5 third channel", int'(startChan), 7);
    check("R9 busy before last done", int'(busy), 1);
    tick(2);
    manualDone = 1'b1; tick(1); manualDone = 1'b0; #1;
    check("R9 busy cleared by last done", int'(busy), 0);
    autoDone = 1'b1;
    tick(2);

    // R10 empty mask
    globalEn = 1'b0;
    setCtrl(3, 0, 0, 0, 1);
    globalEn = 1'b1;
    wrReg(1'b1, 16'h0000);
    base = logCnt;
    syncStartIn = 1'b1; tick(1); syncStartIn = 1'b0;
    trigIn[0] = 1'b1; tick(6); trigIn[0] = 1'b0; tick(6); #1;
    check("R10 no request on empty mask", logCnt - base, 0);
    check("R10 busy stays low", int'(busy), 0);

    // R8 software start ignored in sync mode, R7 sync launch
    globalEn = 1'b0;
    setCtrl(0, 0, 0, 0, 1);
    globalEn = 1'b1;
    wrReg(1'b1, 16'h0010);
    base = logCnt;
    swStart(); tick(3); #1;
    check("R8 software start ignored in sync mode", logCnt - base, 0);
    syncStartIn = 1'b1; tick(1); syncStartIn = 1'b0; #1;
    check("R7 sync launch next cycle", int'(startReq), 1);
    check("R7 sync channel", int'(startChan), 4);
    tick(3);

    finishRun();
  end

endmodule